// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock of an I2C master on an open-drain line. It never drives the line high. It only asserts a pull-low output, and the external pull-up returns the line high. The low phase and the high phase each last a programmable number of ticks. The two lengths are held in separate 8-bit fields, and the tick rate comes from a prescaler on the kernel clock.

Timing of each phase begins from the line level the block actually observes, not from its own drive. That level is taken after a two-stage synchronizer and an optional digital glitch filter. So a slave that holds the line low stretches the clock. Another master that pulls the line low early is followed, and the local low phase restarts from that point.

The block also raises one-cycle strobes on each detected falling and rising edge of the line, for use by data-shifting logic.

Top module: `scl_master_clkgen`

## Requirements
- R1: While `en` is low, `scl_pull` is 0 from the next clock on, and `fall_stb` and `rise_stb` are 0.
- R2: After `en` rises with the line high, `scl_pull` first becomes 1 after (hi_len+1)×(pre_div+1) kernel clocks.
- R3: A low phase starts at a detected falling edge. `scl_pull` is released (goes to 0) exactly (lo_len+1)×(pre_div+1) clocks later. With a free line, `scl_pull` stays 1 for 3+flt_len+(lo_len+1)×(pre_div+1) clocks.
- R4: A high phase starts at a detected rising edge. `scl_pull` returns to 1 exactly (hi_len+1)×(pre_div+1) clocks later. With a free line, `scl_pull` stays 0 for 3+flt_len+(hi_len+1)×(pre_div+1) clocks.
- R5: Suppose a level change on `scl_in` is present before clock edge k, and the glitch filter accepts it. Then `fall_stb` (for high to low) or `rise_stb` (for low to high) is 1 for exactly the one cycle after edge k+1+flt_len. The two strobes are never 1 together.
- R6: When flt_len is nonzero, a new line level is accepted only after it has held for flt_len consecutive clocks. A shorter pulse produces no strobe and does not change the phase timing. flt_len = 0 bypasses the filter.
- R7: The high phase count starts only once the line is seen high. If the line is held low after release, `scl_pull` returns to 1 at 3+flt_len+(hi_len+1)×(pre_div+1) clocks after the line is let go.
- R8: If the line is seen falling while the block is in its high phase, the block asserts `scl_pull` at that detection and starts a fresh low phase of (lo_len+1)×(pre_div+1) clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_k | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low clears all counting state |
| pre_div | input | 4 | Prescaler: one tick every pre_div+1 clocks |
| lo_len | input | 8 | Low phase length in ticks, minus one |
| hi_len | input | 8 | High phase length in ticks, minus one |
| flt_len | input | 4 | Glitch filter length in clocks; 0 bypasses |
| scl_in | input | 1 | Raw line level |
| scl_pull | output | 1 | 1 pulls the line low |
| fall_stb | output | 1 | One-cycle strobe on a detected falling edge |
| rise_stb | output | 1 | One-cycle strobe on a detected rising edge |

## Verification
The bench sweeps prescaler, length and filter settings, including zero lengths, a 256-tick low phase and the largest filter setting. A design that counted from its own drive instead of the observed level would give phase lengths short by 3+flt_len. Holding the line low after release checks that the high count waits for the line. A counter that started at release would re-assert the pull too early. A foreign low pulse during the high phase must bring the pull in at once, one synchronizer-plus-filter delay later. A design that ignored it would keep its own high phase. A low pulse shorter than the filter length must leave the timing untouched. A filter that was off by one clock would emit a strobe and cut the high phase short.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_HIGH      = 2'd0,
    PH_WAIT_LOW  = 2'd1,
    PH_LOW       = 2'd2,
    PH_WAIT_HIGH = 2'd3
  } scl_phase_e;

  // Phases in which the tick counter advances.
  function automatic logic phase_counts(scl_phase_e p);
    return (p == PH_LOW) || (p == PH_HIGH);
  endfunction

  // Phases that a detected falling edge turns into a low phase.
  function automatic logic fall_starts_low(scl_phase_e p);
    return (p == PH_HIGH) || (p == PH_WAIT_LOW);
  endfunction

endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/scl_glitch_filter.sv
module scl_glitch_filter #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LEN_W-1:0] len,
  input  logic             d,
  output logic             lvl
);
  logic             state_q;
  logic [LEN_W-1:0] run_q;
  logic             bypass;
  logic             held_enough;

  assign bypass      = (len == '0);
  assign held_enough = (({1'b0, run_q} + (LEN_W+1)'(1)) == {1'b0, len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b1;
      run_q   <= '0;
    end else if (!en) begin
      state_q <= 1'b1;
      run_q   <= '0;
    end else if (bypass) begin
      state_q <= d;
      run_q   <= '0;
    end else if (d == state_q) begin
      run_q   <= '0;
    end else if (held_enough) begin
      state_q <= d;
      run_q   <= '0;
    end else begin
      run_q   <= run_q + LEN_W'(1);
    end
  end

  assign lvl = bypass ? d : state_q;
endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pcnt_q;

  assign tick = run && !restart && (pcnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pcnt_q <= '0;
    else if (!run || restart) pcnt_q <= '0;
    else if (tick)            pcnt_q <= '0;
    else                      pcnt_q <= pcnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/scl_master_clkgen.sv
module scl_master_clkgen
  import scl_gen_pkg::*;
#(
  parameter int DIV_W       = 4,
  parameter int CNT_W       = 8,
  parameter int FLT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_k,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] pre_div,
  input  logic [CNT_W-1:0] lo_len,
  input  logic [CNT_W-1:0] hi_len,
  input  logic [FLT_W-1:0] flt_len,
  input  logic             scl_in,
  output logic             scl_pull,
  output logic             fall_stb,
  output logic             rise_stb
);
  logic             sync_lvl;
  logic             lvl_f;
  logic             lvl_q;
  logic             ph_tick;
  logic             start_low;
  logic             start_high;
  logic             cnt_run;
  logic             cnt_hit;
  logic [CNT_W-1:0] target;
  scl_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pull_q;

  scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_k), .rst_n(rst_n), .d(scl_in), .q(sync_lvl)
  );

  scl_glitch_filter #(.LEN_W(FLT_W)) u_filt (
    .clk(clk_k), .rst_n(rst_n), .en(en), .len(flt_len), .d(sync_lvl), .lvl(lvl_f)
  );

  // Edge detection on the filtered level
  always_ff @(posedge clk_k or negedge rst_n) begin
    if (!rst_n)   lvl_q <= 1'b1;
    else if (!en) lvl_q <= 1'b1;
    else          lvl_q <= lvl_f;
  end

  assign fall_stb = en &&  lvl_q && !lvl_f;
  assign rise_stb = en && !lvl_q &&  lvl_f;

  assign start_low  = fall_stb && fall_starts_low(phase_q);
  assign start_high = rise_stb && (phase_q == PH_WAIT_HIGH);
  assign cnt_run    = en && phase_counts(phase_q);
  assign target     = (phase_q == PH_LOW) ? lo_len : hi_len;
  assign cnt_hit    = (cnt_q == target);

  scl_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk_k), .rst_n(rst_n), .run(cnt_run),
    .restart(start_low || start_high), .div(pre_div), .tick(ph_tick)
  );

  always_ff @(posedge clk_k or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HIGH;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
    end else if (!en) begin
      phase_q <= PH_HIGH;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
    end else if (start_low) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
      pull_q  <= 1'b1;
    end else if (start_high) begin
      phase_q <= PH_HIGH;
      cnt_q   <= '0;
    end else if (ph_tick) begin
      if (cnt_hit) begin
        cnt_q <= '0;
        if (phase_q == PH_LOW) begin
          pull_q  <= 1'b0;
          phase_q <= PH_WAIT_HIGH;
        end else begin
          pull_q  <= 1'b1;
          phase_q <= PH_WAIT_LOW;
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign scl_pull = pull_q;
endmodule

// File: rtl/scl_clkgen_checker.sv
module scl_clkgen_checker #(
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [DIV_W-1:0] pre_div,
  input logic             scl_pull,
  input logic             fall_stb,
  input logic             rise_stb,
  input logic             filt_lvl,
  input logic             tick
);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !scl_pull);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!fall_stb && !rise_stb));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_stb, rise_stb}));

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
    fall_stb |=> !fall_stb);

  // R3
  release_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
    ($fell(scl_pull) && $past(en)) |-> !$past(filt_lvl));

  // R4
  assert_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
    ($rose(scl_pull) && $past(en)) |-> ($past(filt_lvl) || $past(fall_stb)));

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (tick && pre_div != '0) |=> !tick);
endmodule

bind scl_master_clkgen scl_clkgen_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk_k), .rst_n(rst_n), .en(en), .pre_div(pre_div),
  .scl_pull(scl_pull), .fall_stb(fall_stb), .rise_stb(rise_stb),
  .filt_lvl(lvl_f), .tick(ph_tick)
);

// File: tb/scl_master_clkgen_bench.sv
module scl_master_clkgen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] pre_div = '0;
  logic [7:0] lo_len = '0;
  logic [7:0] hi_len = '0;
  logic [3:0] flt_len = '0;
  logic       ext_low = 1'b0;
  logic       scl_line;
  logic       scl_pull, fall_stb, rise_stb;
  int         n_chk = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  assign scl_line = ~(scl_pull | ext_low);

  scl_master_clkgen u_scl_master_clkgen (
    .clk_k(clk), .rst_n(rst_n), .en(en), .pre_div(pre_div),
    .lo_len(lo_len), .hi_len(hi_len), .flt_len(flt_len),
    .scl_in(scl_line), .scl_pull(scl_pull), .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  // Stimulus table: {pre_div, lo_len, hi_len, flt_len}
  localparam int NV = 7;
  localparam logic [23:0] VECS [0:NV-1] = '{
    {4'd0,  8'd3,   8'd2, 4'd0},
    {4'd1,  8'd4,   8'd6, 4'd0},
    {4'd2,  8'd1,   8'd1, 4'd2},
    {4'd0,  8'd0,   8'd0, 4'd0},
    {4'd3,  8'd7,   8'd5, 4'd4},
    {4'd15, 8'd2,   8'd3, 4'd15},
    {4'd0,  8'd255, 8'd9, 4'd1}
  };

  // Counting clocks of one phase: len+1 ticks, each pre+1 clocks long.
  function automatic int phase_clks(int len, int pre);
    return len * pre + len + pre + 1;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Wait for scl_pull == v, sampling at negedges; note strobe positions.
  task automatic wait_pull(input logic v, output int cyc, output int f_first,
                           output int f_n, output int r_first, output int r_n);
    cyc = 0; f_first = -1; r_first = -1; f_n = 0; r_n = 0;
    while (scl_pull !== v && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (fall_stb) begin if (f_first < 0) f_first = cyc; f_n++; end
      if (rise_stb) begin if (r_first < 0) r_first = cyc; r_n++; end
    end
  endtask

  task automatic configure(input int p, input int l, input int h, input int d);
    en = 1'b0; ext_low = 1'b0;
    repeat (8) @(negedge clk);
    pre_div = 4'(p); lo_len = 8'(l); hi_len = 8'(h); flt_len = 4'(d);
    repeat (2) @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): actual 150000 cycles expected completion");
    summary();
    $finish;
  end

  initial begin
    int c, ff, fn, rf, rn;
    // Reset state (R1)
    repeat (3) @(negedge clk);
    check("R1", "pull in reset", int'(scl_pull), 0);
    check("R1", "fall_stb in reset", int'(fall_stb), 0);
    check("R1", "rise_stb in reset", int'(rise_stb), 0);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      int p, l, h, d;
      p = int'(VECS[i][23:20]); l = int'(VECS[i][19:12]);
      h = int'(VECS[i][11:4]);  d = int'(VECS[i][3:0]);
      configure(p, l, h, d);
      wait_pull(1'b1, c, ff, fn, rf, rn);
      check("R2", $sformatf("vec%0d first pull", i), c, phase_clks(h, p));
      wait_pull(1'b0, c, ff, fn, rf, rn);
      check("R3", $sformatf("vec%0d low span", i), c, 3 + d + phase_clks(l, p));
      check("R5", $sformatf("vec%0d fall strobe pos", i), ff, 2 + d);
      check("R5", $sformatf("vec%0d fall strobe count", i), fn, 1);
      wait_pull(1'b1, c, ff, fn, rf, rn);
      check("R4", $sformatf("vec%0d high span", i), c, 3 + d + phase_clks(h, p));
      check("R5", $sformatf("vec%0d rise strobe pos", i), rf, 2 + d);
      en = 1'b0;
      @(negedge clk);
      check("R1", $sformatf("vec%0d pull after disable", i), int'(scl_pull), 0);
      check("R1", $sformatf("vec%0d strobes after disable", i), int'(fall_stb | rise_stb), 0);
    end

    // R8: another master pulls low during the high phase
    configure(1, 3, 20, 1);
    wait_pull(1'b1, c, ff, fn, rf, rn);
    wait_pull(1'b0, c, ff, fn, rf, rn);
    repeat (9) @(negedge clk);
    ext_low = 1'b1;
    wait_pull(1'b1, c, ff, fn, rf, rn);
    check("R8", "pull after foreign low", c, 4);
    ext_low = 1'b0;
    wait_pull(1'b0, c, ff, fn, rf, rn);
    check("R8", "restarted low span", c, phase_clks(3, 1));

    // R6: a 2-clock glitch with flt_len=3 is rejected
    configure(1, 3, 20, 3);
    wait_pull(1'b1, c, ff, fn, rf, rn);
    wait_pull(1'b0, c, ff, fn, rf, rn);
    repeat (10) @(negedge clk);
    ext_low = 1'b1;
    repeat (2) @(negedge clk);
    ext_low = 1'b0;
    wait_pull(1'b1, c, ff, fn, rf, rn);
    check("R6", "high span with glitch", 12 + c, 3 + 3 + phase_clks(20, 1));
    check("R6", "fall strobes from glitch", fn, 0);

    // R7: slave stretches the low phase
    configure(0, 5, 6, 0);
    wait_pull(1'b1, c, ff, fn, rf, rn);
    ext_low = 1'b1;
    wait_pull(1'b0, c, ff, fn, rf, rn);
    check("R3", "low span under stretch", c, 3 + phase_clks(5, 0));
    begin
      int rises = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (rise_stb) rises++;
        if (scl_pull) rises += 100;
      end
      check("R7", "no high phase while held", rises, 0);
    end
    ext_low = 1'b0;
    wait_pull(1'b1, c, ff, fn, rf, rn);
    check("R7", "pull after stretch end", c, 3 + phase_clks(6, 0));

    en = 1'b0;
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule